// File: doc/BRIEF.md
# Power-Managed Mode Sequencer

This block decides when a small processor core and its peripherals receive clocks. In normal execution both clock enables are high. A sleep strobe moves the block into a low-power state. With the idle-enable bit set, that state is an idle state: the core is gated and the peripherals keep running. With the bit clear, it is a full sleep: the core, the peripherals and the primary oscillator all stop.

The block leaves the low-power state on an enabled interrupt, a reset request or a watchdog time-out. The core then stays gated for a fixed settle delay. In its first cycle back it receives exactly one one-cycle strobe. That strobe sends it to the interrupt vector when the wake came from an interrupt with global interrupt enable set. In every other case it tells the core to resume in place.

The block also gives the enable for the primary oscillator and tracks its ready flag. Separately it tracks when the internal oscillator has become stable, based on the frequency-select and source-select bits. The oscillators, the watchdog counter and the instruction decoder are outside the block and are seen only as inputs.

Top module: `pm_sequencer`

## Requirements
- R1: A sleep strobe in the running state with `idle_en_i` high gives the idle state from the next cycle: `cpu_clk_en_o` low and `per_clk_en_o` high.
- R2: A sleep strobe in the running state with `idle_en_i` low gives the sleep state from the next cycle: `cpu_clk_en_o`, `per_clk_en_o` and `pri_osc_en_o` all low.
- R3: `pri_osc_en_o` is low whenever `clk_sel_i[1]` is 1 (internal oscillator path) or the block is in sleep. `clk_sel_i[0]` has no effect. `pri_stable_o` is, one cycle later, the AND of `pri_osc_en_o` and `pri_rdy_i`, so it is cleared the cycle after the primary oscillator is switched off.
- R4: The internal oscillator counts as on when `osc_freq_i` is nonzero or `int_src_i` is 1, and the block is not in sleep. `int_stable_o` goes high STAB_CYC cycles after the first cycle in which it is on, and stays high while it remains on. Clock enables are unaffected during that interval.
- R5: When `osc_freq_i` is zero and `int_src_i` is 0, `int_stable_o` is low from the next cycle on.
- R6: In idle or sleep, the block detects a wake in any cycle with an interrupt flag whose enable bit is set, `rst_req_i`, or `wdt_to_i`. A flag whose enable bit is 0 causes no wake.
- R7: After the cycle in which a wake is detected, `cpu_clk_en_o` stays low for exactly SETTLE_CYC cycles (default 4) with `per_clk_en_o` high. It is high in the cycle after those.
- R8: In the first cycle with `cpu_clk_en_o` high after a wake, exactly one of `vector_o` and `resume_o` is high, for one cycle. `vector_o` is chosen when an enabled interrupt flag and `gie_i` were both high in the wake cycle; otherwise `resume_o` is chosen. Neither strobe is high at any other time.
- R9: A sleep strobe received in idle, sleep or during the settle delay is ignored.
- R10: Wake inputs (interrupt flags, `rst_req_i`, `wdt_to_i`) have no effect while the block is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep instruction strobe |
| idle_en_i | input | 1 | Selects idle (1) or sleep (0) on a sleep strobe |
| clk_sel_i | input | 2 | System clock select; bit 1 selects the internal oscillator path |
| osc_freq_i | input | FREQ_W | Internal oscillator frequency select |
| int_src_i | input | 1 | Internal source select |
| irq_flag_i | input | N_IRQ | Interrupt flags |
| irq_en_i | input | N_IRQ | Interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| rst_req_i | input | 1 | Reset request (wake cause) |
| wdt_to_i | input | 1 | Watchdog time-out (wake cause) |
| pri_rdy_i | input | 1 | Primary oscillator ready |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| pri_stable_o | output | 1 | Primary oscillator ready status |
| int_stable_o | output | 1 | Internal oscillator stable status |
| vector_o | output | 1 | Branch-to-vector strobe |
| resume_o | output | 1 | Resume-in-place strobe |

## Verification
The bench exercises these corner cases:
- An interrupt flag raised with its enable clear. A design that ignored the mask would wake early.
- Wakes from idle and from sleep by each of the three causes, with `gie_i` both set and clear. A vector/resume mix-up or a settle count off by one shows up as a wrong strobe or a wrong number of gated cycles.
- Repeated sleep strobes in idle and during the settle delay. A design that re-entered a low-power state on them would leave the core gated.
- Dropping both oscillator-select fields, then restoring one. A stable flag that is not cleared, or that is raised at the wrong time, is caught in that sequence.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_SLEEP  = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_e;

  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_VECTOR = 2'd1,
    WK_RESUME = 2'd2
  } wake_act_e;
endpackage

// File: rtl/pm_wake_detect.sv
module pm_wake_detect
  import pm_seq_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             gie_i,
  input  logic             rst_req_i,
  input  logic             wdt_to_i,
  output logic             wake_o,
  output wake_act_e        act_o
);
  logic [N_IRQ-1:0] hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
    assign hit[i] = irq_flag_i[i] & irq_en_i[i];
  end

  logic irq_wake;
  assign irq_wake = |hit;
  assign wake_o   = irq_wake | rst_req_i | wdt_to_i;

  always_comb begin
    if (!wake_o)              act_o = WK_NONE;
    else if (irq_wake && gie_i) act_o = WK_VECTOR;
    else                      act_o = WK_RESUME;
  end
endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(CYC - 1);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = act_q && (cnt_q == '0);
endmodule

// File: rtl/pm_osc_stab.sv
module pm_osc_stab #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  output logic stable_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!on_i) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      if (cnt_q == CW'(CYC - 1)) stable_q <= 1'b1;
      else                       cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign stable_o = stable_q;
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
  import pm_seq_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int FREQ_W     = 3,
  parameter int SETTLE_CYC = 4,
  parameter int STAB_CYC   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              idle_en_i,
  input  logic [1:0]        clk_sel_i,
  input  logic [FREQ_W-1:0] osc_freq_i,
  input  logic              int_src_i,
  input  logic [N_IRQ-1:0]  irq_flag_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic              gie_i,
  input  logic              rst_req_i,
  input  logic              wdt_to_i,
  input  logic              pri_rdy_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              pri_osc_en_o,
  output logic              pri_stable_o,
  output logic              int_stable_o,
  output logic              vector_o,
  output logic              resume_o
);
  pm_state_e state_q, state_d;
  wake_act_e wk_act, act_q;
  logic      wake, settle_start, settle_done;
  logic      vec_q, res_q, pri_st_q, int_on;

  pm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_flag_i (irq_flag_i),
    .irq_en_i   (irq_en_i),
    .gie_i      (gie_i),
    .rst_req_i  (rst_req_i),
    .wdt_to_i   (wdt_to_i),
    .wake_o     (wake),
    .act_o      (wk_act)
  );

  pm_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (settle_start),
    .done_o  (settle_done)
  );

  // sleep stops the internal path too; idle keeps it alive
  assign int_on = ((|osc_freq_i) || int_src_i) && (state_q != PM_SLEEP);

  pm_osc_stab #(.CYC(STAB_CYC)) u_stab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .on_i     (int_on),
    .stable_o (int_stable_o)
  );

  always_comb begin
    state_d      = state_q;
    settle_start = 1'b0;
    unique case (state_q)
      PM_RUN:    if (sleep_i) state_d = idle_en_i ? PM_IDLE : PM_SLEEP;
      PM_IDLE,
      PM_SLEEP:  if (wake) begin
                   state_d      = PM_SETTLE;
                   settle_start = 1'b1;
                 end
      PM_SETTLE: if (settle_done) state_d = PM_RUN;
      default:   state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PM_RUN;
      act_q    <= WK_NONE;
      vec_q    <= 1'b0;
      res_q    <= 1'b0;
      pri_st_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (settle_start) act_q <= wk_act;
      vec_q    <= (state_q == PM_SETTLE) && settle_done && (act_q == WK_VECTOR);
      res_q    <= (state_q == PM_SETTLE) && settle_done && (act_q == WK_RESUME);
      pri_st_q <= pri_osc_en_o && pri_rdy_i;
    end
  end

  assign cpu_clk_en_o = (state_q == PM_RUN);
  assign per_clk_en_o = (state_q != PM_SLEEP);
  assign pri_osc_en_o = !clk_sel_i[1] && (state_q != PM_SLEEP);
  assign pri_stable_o = pri_st_q;
  assign vector_o     = vec_q;
  assign resume_o     = res_q;
endmodule

// File: rtl/pm_sequencer_chk.sv
module pm_sequencer_chk
  import pm_seq_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int FREQ_W     = 3,
  parameter int SETTLE_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic [1:0]        clk_sel_i,
  input logic [FREQ_W-1:0] osc_freq_i,
  input logic              int_src_i,
  input logic [N_IRQ-1:0]  irq_flag_i,
  input logic [N_IRQ-1:0]  irq_en_i,
  input logic              rst_req_i,
  input logic              wdt_to_i,
  input logic              cpu_clk_en_o,
  input logic              per_clk_en_o,
  input logic              pri_osc_en_o,
  input logic              pri_stable_o,
  input logic              int_stable_o,
  input logic              vector_o,
  input logic              resume_o,
  input pm_state_e         state_q
);
  logic wk;
  assign wk = (|(irq_flag_i & irq_en_i)) || rst_req_i || wdt_to_i;

  int unsigned sc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   sc_q <= 0;
    else if (state_q == PM_SETTLE) sc_q <= sc_q + 1;
    else                           sc_q <= 0;
  end

  AST_IDLE_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PM_IDLE |-> !cpu_clk_en_o && per_clk_en_o); // R1
  AST_SLEEP_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PM_SLEEP |-> !cpu_clk_en_o && !per_clk_en_o && !pri_osc_en_o); // R2
  AST_PRI_FLAG_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pri_osc_en_o |=> !pri_stable_o); // R3
  AST_PRI_INT_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_i[1] |-> !pri_osc_en_o); // R3
  AST_INT_OFF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_freq_i == '0 && !int_src_i) |=> !int_stable_o); // R5
  AST_WAKE_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_IDLE || state_q == PM_SLEEP) && wk |=> state_q == PM_SETTLE); // R6
  AST_SETTLE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PM_SETTLE |-> sc_q < SETTLE_CYC); // R7
  AST_SETTLE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_RUN && $past(state_q) == PM_SETTLE) |-> $past(sc_q) == SETTLE_CYC - 1); // R7
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vector_o, resume_o})); // R8
  AST_STROBE_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vector_o || resume_o) |-> cpu_clk_en_o && $past(state_q) == PM_SETTLE); // R8
  AST_IDLE_SLEEP_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PM_IDLE && sleep_i && !wk |=> state_q == PM_IDLE); // R9
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PM_RUN && !sleep_i |=> state_q == PM_RUN); // R10
endmodule

bind pm_sequencer pm_sequencer_chk #(
  .N_IRQ(N_IRQ), .FREQ_W(FREQ_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .clk_sel_i(clk_sel_i),
  .osc_freq_i(osc_freq_i), .int_src_i(int_src_i), .irq_flag_i(irq_flag_i),
  .irq_en_i(irq_en_i), .rst_req_i(rst_req_i), .wdt_to_i(wdt_to_i),
  .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
  .pri_osc_en_o(pri_osc_en_o), .pri_stable_o(pri_stable_o),
  .int_stable_o(int_stable_o), .vector_o(vector_o), .resume_o(resume_o),
  .state_q(state_q)
);

// File: tb/tb_pm_sequencer.sv
`timescale 1ns/1ps
module tb_pm_sequencer;
  localparam int N_IRQ  = 8;
  localparam int FREQ_W = 3;
  localparam int SETTLE = 4;
  localparam int STAB   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep = 0, idle_en = 0, int_src = 0, gie = 0, rst_req = 0, wdt = 0, pri_rdy = 1;
  logic [1:0] clk_sel = '0;
  logic [FREQ_W-1:0] freq = '0;
  logic [N_IRQ-1:0] irq_flag = '0, irq_en = '0;
  logic cpu, per, pri_en, pri_st, int_st, vec, res;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pm_sequencer #(.N_IRQ(N_IRQ), .FREQ_W(FREQ_W), .SETTLE_CYC(SETTLE), .STAB_CYC(STAB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .idle_en_i(idle_en), .clk_sel_i(clk_sel),
    .osc_freq_i(freq), .int_src_i(int_src), .irq_flag_i(irq_flag), .irq_en_i(irq_en),
    .gie_i(gie), .rst_req_i(rst_req), .wdt_to_i(wdt), .pri_rdy_i(pri_rdy),
    .cpu_clk_en_o(cpu), .per_clk_en_o(per), .pri_osc_en_o(pri_en), .pri_stable_o(pri_st),
    .int_stable_o(int_st), .vector_o(vec), .resume_o(res)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: 0 run, 1 idle, 2 sleep, 3 settle
  int m_state, m_cnt, m_stab;
  bit m_vec_pend, m_vec, m_res, m_pst, m_ist;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_stab = 0; m_vec_pend = 0;
      m_vec = 0; m_res = 0; m_pst = 0; m_ist = 0;
    end else begin
      bit irq_hit, wk, pe, io;
      irq_hit = (irq_flag & irq_en) != 0;
      wk = irq_hit || rst_req || wdt;
      pe = !clk_sel[1] && m_state != 2;
      io = (freq != 0 || int_src) && m_state != 2;
      m_pst = pe && pri_rdy;
      if (io) begin
        if (m_stab >= STAB - 1) m_ist = 1; else m_stab++;
      end else begin
        m_stab = 0; m_ist = 0;
      end
      m_vec = 0; m_res = 0;
      case (m_state)
        0: if (sleep) m_state = idle_en ? 1 : 2;
        1, 2: if (wk) begin m_state = 3; m_cnt = SETTLE; m_vec_pend = irq_hit && gie; end
        default: begin
          m_cnt--;
          if (m_cnt == 0) begin
            m_state = 0; m_vec = m_vec_pend; m_res = !m_vec_pend;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7", "cpu_clk_en", cpu, m_state == 0);
      chk("R1", "per_clk_en", per, m_state != 2);
      chk("R3", "pri_osc_en", pri_en, !clk_sel[1] && m_state != 2);
      chk("R3", "pri_stable", pri_st, m_pst);
      chk("R4", "int_stable", int_st, m_ist);
      chk("R8", "vector", vec, m_vec);
      chk("R8", "resume", res, m_res);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_sleep();
    sleep = 1; step(1); sleep = 0;
  endtask

  // caller has driven a wake cause; it is captured by the next edge
  task automatic wake_measure(input string why, input bit exp_vec);
    int n = 0;
    step(1);
    irq_flag = '0; rst_req = 0; wdt = 0;
    while (n < 50) begin
      @(negedge clk);
      if (cpu) break;
      n++;
      chk("R7", {why, " per on in settle"}, per, 1);
    end
    chk("R7", {why, " settle length"}, n, SETTLE);
    chk("R8", {why, " vector"}, vec, exp_vec);
    chk("R8", {why, " resume"}, res, !exp_vec);
    step(1);
  endtask

  initial begin
    #10;
    chk("R7", "reset cpu", cpu, 1);
    chk("R1", "reset per", per, 1);
    chk("R8", "reset strobes", vec | res, 0);
    #12 rst_n = 1;
    step(2);

    // R10: wake inputs in run do nothing
    wdt = 1; rst_req = 1; irq_en = 8'h01; irq_flag = 8'h01; step(1);
    wdt = 0; rst_req = 0; irq_flag = 0; step(1);
    @(negedge clk); chk("R10", "run ignores wake", cpu, 1);
    step(1);

    // R4: internal oscillator stabilisation
    freq = 3; step(STAB - 1);
    @(negedge clk); chk("R4", "not yet stable", int_st, 0);
    step(1);
    @(negedge clk); chk("R4", "stable", int_st, 1);
    step(1);

    // R1 / R3: switch to internal path, idle
    idle_en = 1; clk_sel = 2'b11; step(1);
    @(negedge clk); chk("R3", "pri flag cleared", pri_st, 0);
    step(1);
    pulse_sleep();
    @(negedge clk); chk("R1", "idle cpu", cpu, 0); chk("R1", "idle per", per, 1);
    step(1);
    pulse_sleep();
    @(negedge clk); chk("R9", "sleep in idle ignored", per, 1);
    step(1);
    irq_flag = 8'h04; irq_en = 8'h01; step(3);
    @(negedge clk); chk("R6", "masked flag no wake", cpu, 0);
    step(1);
    irq_en = 8'h05; gie = 1;
    wake_measure("irq gie", 1);

    // R2: full sleep, watchdog wake
    clk_sel = 2'b01; idle_en = 0; step(2);
    pulse_sleep();
    @(negedge clk); chk("R2", "sleep per", per, 0); chk("R2", "sleep pri", pri_en, 0);
    step(1);
    pulse_sleep();
    @(negedge clk); chk("R9", "sleep in sleep ignored", cpu, 0);
    step(2);
    wdt = 1; wake_measure("wdt", 0);

    // reset-request wake from sleep
    step(3); pulse_sleep(); step(2);
    rst_req = 1; wake_measure("rst", 0);

    // interrupt with gie clear resumes in place; R6 from idle
    idle_en = 1; gie = 0; step(2); pulse_sleep(); step(2);
    irq_flag = 8'h01; irq_en = 8'h01; wake_measure("irq nogie", 0);

    // R9: sleep strobe during settle
    pulse_sleep(); step(1);
    wdt = 1; step(1); wdt = 0;
    pulse_sleep(); step(SETTLE + 2);
    @(negedge clk); chk("R9", "sleep in settle ignored", cpu, 1);
    step(1);

    // R5: both select fields clear
    freq = 0; int_src = 0; step(1);
    @(negedge clk); chk("R5", "int stable dropped", int_st, 0);
    step(5);
    @(negedge clk); chk("R5", "int stable stays low", int_st, 0);
    step(1);
    int_src = 1; step(STAB);
    @(negedge clk); chk("R4", "src alone stabilises", int_st, 1);

    // R3: primary ready follows input
    pri_rdy = 0; step(1);
    @(negedge clk); chk("R3", "pri flag follows rdy", pri_st, 0);
    pri_rdy = 1; step(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule